// File: doc/BRIEF.md
# UART Interrupt Pin Generator

This block produces the interrupt output for one channel of a two-channel UART. It does not hold any data. It reads the channel's state: the mode control bits, the status flags of the transmit holding and shift registers, a received-byte flag, and the fill counts of both FIFOs. From these it forms a transmit-ready condition and a receive-data condition. It masks each condition with its own enable and ORs the results into a single active-high pin. The pin comes out of a register on the system clock.

Two controls choose how the transmit condition is formed. The queue-enable bit selects single-byte operation (0) or FIFO operation (1). The half-duplex line-turnaround flag (auto RS-485 operation) delays the transmit interrupt. With this flag set, the interrupt waits until the shift register has also drained, so software can safely turn the line driver around. The trigger levels are compared against the fill counts. A count is "at or above" its trigger when it is greater than or equal to the trigger value.

Top module: `uirq_pin_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `irq` is low after that edge, whatever the other inputs are.
- R2: After every rising edge with `rst` low, `irq` shows the function in R3 to R9 of the inputs sampled at that edge. A change of mode or enable therefore appears exactly one cycle later.
- R3: With `q_en`=0 (single-byte) and `hd485`=0, the transmit condition equals `thr_empty`.
- R4: With `q_en`=0 and `hd485`=1, the transmit condition is `thr_empty` AND `tsr_empty`. It stays low while the shift register is busy.
- R5: With `q_en`=1 and `hd485`=0, the transmit condition is high when `tx_cnt` < `tx_trig` or when `tx_cnt` is 0. It is low when `tx_cnt` is non-zero and at or above `tx_trig`.
- R6: With `q_en`=1 and `hd485`=1, the transmit condition is high when `tx_cnt` < `tx_trig`, or when `tx_cnt` is 0 and `tsr_empty`=1. Otherwise it is low.
- R7: With `q_en`=0, the receive condition equals `rx_hold`, and `rx_cnt` and `rx_trig` have no effect.
- R8: With `q_en`=1, the receive condition is high when `rx_cnt` >= `rx_trig` and `rx_cnt` is non-zero, and `rx_hold` has no effect.
- R9: `irq` is (transmit condition AND `tx_ie`) OR (receive condition AND `rx_ie`). With both enables low it stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| q_en | input | 1 | 0 selects single-byte operation, 1 selects FIFO operation |
| hd485 | input | 1 | Half-duplex turnaround mode: transmit interrupt waits for the shifter |
| thr_empty | input | 1 | Transmit holding register holds no byte |
| tsr_empty | input | 1 | Transmit shift register idle and empty |
| tx_cnt | input | LVL_W (7) | Transmit FIFO fill count |
| tx_trig | input | LVL_W (7) | Transmit trigger level |
| rx_hold | input | 1 | Single-byte receive holding register has a byte |
| rx_cnt | input | LVL_W (7) | Receive FIFO fill count |
| rx_trig | input | LVL_W (7) | Receive trigger level |
| tx_ie | input | 1 | Transmit-ready interrupt enable |
| rx_ie | input | 1 | Receive-data interrupt enable |
| irq | output | 1 | Registered active-high interrupt pin |

## Verification
The bench works on the transmit count boundaries: a count equal to the trigger, one below it, and the empty FIFO with a trigger of zero. A design that used a strict comparison, or that left out the empty case, would leave the pin high or low on the wrong side of the edge. In turnaround mode the bench keeps the shift register busy while the holding register or FIFO is empty. A design that ignored `tsr_empty` would fire early and cut off the last character. The bench also toggles the stale inputs of the inactive mode (`rx_hold` in FIFO mode, `rx_cnt` in single-byte mode) and changes the mode on back-to-back cycles. A design that decoded the wrong mode, or that added a cycle of delay, would show a wrong pin value in the cycle after the change.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int unsigned DEF_DEPTH = 64;

  // queue-enable encoding
  typedef enum logic {
    QM_BYTE = 1'b0,
    QM_FIFO = 1'b1
  } qmode_e;
endpackage

// File: rtl/uirq_tx_cond.sv
module uirq_tx_cond #(
  parameter int unsigned LVL_W = 7
) (
  input  logic             q_en,
  input  logic             hd485,
  input  logic             thr_empty,
  input  logic             tsr_empty,
  input  logic [LVL_W-1:0] tx_cnt,
  input  logic [LVL_W-1:0] tx_trig,
  output logic             tx_cond
);
  import uirq_pkg::*;

  logic   below_trig;
  logic   fifo_empty;
  logic   xmit_idle;
  logic   byte_cond;
  logic   fifo_cond;
  qmode_e mode;

  assign mode       = qmode_e'(q_en);
  assign below_trig = (tx_cnt < tx_trig);
  assign fifo_empty = (tx_cnt == '0);
  assign xmit_idle  = fifo_empty & tsr_empty;

  always_comb begin
    if (hd485) begin
      byte_cond = thr_empty & tsr_empty;
      fifo_cond = below_trig | xmit_idle;
    end else begin
      byte_cond = thr_empty;
      fifo_cond = below_trig | fifo_empty;
    end
  end

  always_comb begin
    unique case (mode)
      QM_FIFO: tx_cond = fifo_cond;
      default: tx_cond = byte_cond;
    endcase
  end
endmodule

// File: rtl/uirq_rx_cond.sv
module uirq_rx_cond #(
  parameter int unsigned LVL_W = 7
) (
  input  logic             q_en,
  input  logic             rx_hold,
  input  logic [LVL_W-1:0] rx_cnt,
  input  logic [LVL_W-1:0] rx_trig,
  output logic             rx_cond
);
  import uirq_pkg::*;

  logic   at_or_above;
  logic   nonempty;
  qmode_e mode;

  assign mode        = qmode_e'(q_en);
  assign at_or_above = (rx_cnt >= rx_trig);
  assign nonempty    = (rx_cnt != '0);

  always_comb begin
    unique case (mode)
      QM_FIFO: rx_cond = at_or_above & nonempty;
      default: rx_cond = rx_hold;
    endcase
  end
endmodule

// File: rtl/uirq_pin_top.sv
module uirq_pin_top #(
  parameter int unsigned DEPTH = uirq_pkg::DEF_DEPTH,
  parameter int unsigned LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             q_en,
  input  logic             hd485,
  input  logic             thr_empty,
  input  logic             tsr_empty,
  input  logic [LVL_W-1:0] tx_cnt,
  input  logic [LVL_W-1:0] tx_trig,
  input  logic             rx_hold,
  input  logic [LVL_W-1:0] rx_cnt,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             tx_ie,
  input  logic             rx_ie,
  output logic             irq
);
  logic tx_cond;
  logic rx_cond;
  logic irq_nxt;
  logic irq_q;

  uirq_tx_cond #(.LVL_W(LVL_W)) u_tx (
    .q_en      (q_en),
    .hd485     (hd485),
    .thr_empty (thr_empty),
    .tsr_empty (tsr_empty),
    .tx_cnt    (tx_cnt),
    .tx_trig   (tx_trig),
    .tx_cond   (tx_cond)
  );

  uirq_rx_cond #(.LVL_W(LVL_W)) u_rx (
    .q_en    (q_en),
    .rx_hold (rx_hold),
    .rx_cnt  (rx_cnt),
    .rx_trig (rx_trig),
    .rx_cond (rx_cond)
  );

  assign irq_nxt = (tx_cond & tx_ie) | (rx_cond & rx_ie);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_nxt;
  end

  assign irq = irq_q;
endmodule

// File: rtl/uirq_pin_chk.sv
module uirq_pin_chk #(
  parameter int unsigned LVL_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             q_en,
  input logic             hd485,
  input logic             thr_empty,
  input logic             tsr_empty,
  input logic [LVL_W-1:0] tx_cnt,
  input logic [LVL_W-1:0] tx_trig,
  input logic             rx_hold,
  input logic [LVL_W-1:0] rx_cnt,
  input logic [LVL_W-1:0] rx_trig,
  input logic             tx_ie,
  input logic             rx_ie,
  input logic             irq
);
  // R1
  a_r1_reset_low: assert property (@(posedge clk) rst |=> !irq);

  // R9: both enables low keeps pin low
  a_r9_masked_low: assert property (@(posedge clk) disable iff (rst)
    (!tx_ie && !rx_ie) |=> !irq);

  // R3 with R2 latency
  a_r3_byte_tx: assert property (@(posedge clk) disable iff (rst)
    (!q_en && !hd485 && tx_ie && !rx_ie) |=> (irq == $past(thr_empty)));

  // R4: busy shifter holds the pin low
  a_r4_shift_busy: assert property (@(posedge clk) disable iff (rst)
    (!q_en && hd485 && tx_ie && !rx_ie && !tsr_empty) |=> !irq);

  // R6: non-empty FIFO at trigger never raises the pin
  a_r6_fifo_busy: assert property (@(posedge clk) disable iff (rst)
    (q_en && tx_ie && !rx_ie && (tx_cnt != '0) && (tx_cnt >= tx_trig)) |=> !irq);

  // R8
  a_r8_rx_fifo: assert property (@(posedge clk) disable iff (rst)
    (q_en && rx_ie && (rx_cnt != '0) && (rx_cnt >= rx_trig)) |=> irq);

  // R7
  a_r7_rx_byte: assert property (@(posedge clk) disable iff (rst)
    (!q_en && rx_ie && rx_hold) |=> irq);

  // R5: empty FIFO always raises the pin in plain mode
  a_r5_fifo_empty: assert property (@(posedge clk) disable iff (rst)
    (q_en && !hd485 && tx_ie && (tx_cnt == '0)) |=> irq);

  logic unused_ok;
  assign unused_ok = ^{thr_empty, rx_trig};
endmodule

bind uirq_pin_top uirq_pin_chk #(.LVL_W(LVL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .q_en      (q_en),
  .hd485     (hd485),
  .thr_empty (thr_empty),
  .tsr_empty (tsr_empty),
  .tx_cnt    (tx_cnt),
  .tx_trig   (tx_trig),
  .rx_hold   (rx_hold),
  .rx_cnt    (rx_cnt),
  .rx_trig   (rx_trig),
  .tx_ie     (tx_ie),
  .rx_ie     (rx_ie),
  .irq       (irq)
);

// File: tb/sim_uirq_pin_top.sv
`timescale 1ns/1ps
module sim_uirq_pin_top;
  localparam int unsigned W = 7;

  logic         clk = 1'b0;
  logic         rst;
  logic         q_en, hd485, thr_empty, tsr_empty, rx_hold, tx_ie, rx_ie;
  logic [W-1:0] tx_cnt, tx_trig, rx_cnt, rx_trig;
  logic         irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  uirq_pin_top u0 (
    .clk(clk), .rst(rst), .q_en(q_en), .hd485(hd485),
    .thr_empty(thr_empty), .tsr_empty(tsr_empty),
    .tx_cnt(tx_cnt), .tx_trig(tx_trig),
    .rx_hold(rx_hold), .rx_cnt(rx_cnt), .rx_trig(rx_trig),
    .tx_ie(tx_ie), .rx_ie(rx_ie), .irq(irq)
  );

  // reference model written from the requirements
  function automatic logic model(
    logic r, logic fe, logic h, logic te, logic se, int tc, int tt,
    logic rh, int rc, int rt, logic ti, logic ri);
    logic tx, rx;
    if (r) return 1'b0;
    if (!fe) tx = h ? (te && se) : te;
    else     tx = (tc < tt) || (tc == 0 && (h ? se : 1'b1));
    if (!fe) rx = rh;
    else     rx = (rc >= rt) && (rc != 0);
    return (tx && ti) || (rx && ri);
  endfunction

  task automatic apply(logic r, logic fe, logic h, logic te, logic se,
                       int tc, int tt, logic rh, int rc, int rt,
                       logic ti, logic ri, logic hand_exp, string tag);
    item_t it;
    @(negedge clk);
    rst = r; q_en = fe; hd485 = h; thr_empty = te; tsr_empty = se;
    tx_cnt = W'(tc); tx_trig = W'(tt); rx_hold = rh;
    rx_cnt = W'(rc); rx_trig = W'(rt); tx_ie = ti; rx_ie = ri;
    it.exp = model(r, fe, h, te, se, tc, tt, rh, rc, rt, ti, ri);
    if (it.exp !== hand_exp) begin
      fails++;
      $display("FAIL %s model mismatch actual=%0b expected=%0b", tag, it.exp, hand_exp);
    end
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (irq !== it.exp) begin
        fails++;
        $display("FAIL %s irq actual=%0b expected=%0b", it.tag, irq, it.exp);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset with inputs that would raise the pin
    apply(1, 0, 0, 1, 1, 0, 8, 1, 0, 8, 1, 1, 0, "R1 reset");
    apply(1, 1, 0, 1, 1, 0, 8, 1, 9, 8, 1, 1, 0, "R1 reset hold");
    // R3 single-byte plain transmit
    apply(0, 0, 0, 1, 0, 0, 8, 0, 0, 8, 1, 0, 1, "R3 thr empty");
    apply(0, 0, 0, 0, 1, 0, 8, 0, 0, 8, 1, 0, 0, "R3 thr full");
    // R4 single-byte turnaround
    apply(0, 0, 1, 1, 0, 0, 8, 0, 0, 8, 1, 0, 0, "R4 shifter busy");
    apply(0, 0, 1, 1, 1, 0, 8, 0, 0, 8, 1, 0, 1, "R4 all empty");
    apply(0, 0, 1, 0, 1, 0, 8, 0, 0, 8, 1, 0, 0, "R4 thr full");
    // R5 FIFO plain transmit boundaries
    apply(0, 1, 0, 0, 0, 7, 8, 0, 0, 8, 1, 0, 1, "R5 one below trig");
    apply(0, 1, 0, 0, 0, 8, 8, 0, 0, 8, 1, 0, 0, "R5 at trig");
    apply(0, 1, 0, 0, 0, 64, 8, 0, 0, 8, 1, 0, 0, "R5 full");
    apply(0, 1, 0, 0, 0, 0, 0, 0, 0, 8, 1, 0, 1, "R5 empty trig0");
    // R6 FIFO turnaround
    apply(0, 1, 1, 0, 0, 0, 0, 0, 0, 8, 1, 0, 0, "R6 empty shifter busy");
    apply(0, 1, 1, 0, 1, 0, 0, 0, 0, 8, 1, 0, 1, "R6 xmit empty");
    apply(0, 1, 1, 0, 0, 3, 8, 0, 0, 8, 1, 0, 1, "R6 below trig");
    apply(0, 1, 1, 1, 1, 9, 8, 0, 0, 8, 1, 0, 0, "R6 above trig");
    // R7 single-byte receive, rx_cnt ignored
    apply(0, 0, 0, 0, 0, 0, 8, 1, 0, 8, 0, 1, 1, "R7 byte held");
    apply(0, 0, 0, 0, 0, 0, 8, 0, 60, 8, 0, 1, 0, "R7 cnt ignored");
    // R8 FIFO receive, rx_hold ignored
    apply(0, 1, 0, 0, 0, 0, 8, 1, 7, 8, 0, 1, 0, "R8 below, hold ignored");
    apply(0, 1, 0, 0, 0, 0, 8, 0, 8, 8, 0, 1, 1, "R8 at trig");
    apply(0, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1, 0, "R8 empty trig0");
    // R9 masking
    apply(0, 0, 0, 1, 1, 0, 8, 1, 0, 8, 0, 0, 0, "R9 both masked");
    apply(0, 0, 0, 1, 1, 0, 8, 0, 0, 8, 0, 1, 0, "R9 tx masked");
    apply(0, 0, 0, 0, 0, 0, 8, 1, 0, 8, 1, 0, 0, "R9 rx masked");
    apply(0, 0, 0, 1, 0, 0, 8, 1, 0, 8, 1, 1, 1, "R9 both set");
    // R2 back-to-back mode changes
    apply(0, 0, 1, 1, 0, 0, 8, 0, 0, 8, 1, 0, 0, "R2 turnaround on");
    apply(0, 0, 0, 1, 0, 0, 8, 0, 0, 8, 1, 0, 1, "R2 turnaround off");
    apply(0, 1, 0, 1, 0, 20, 8, 0, 0, 8, 1, 0, 0, "R2 to fifo");
    apply(0, 0, 0, 1, 0, 20, 8, 0, 0, 8, 1, 0, 1, "R2 to byte");
    // R1 mid-run reset then recovery
    apply(1, 0, 0, 1, 0, 0, 8, 0, 0, 8, 1, 0, 0, "R1 mid reset");
    apply(0, 0, 0, 1, 0, 0, 8, 0, 0, 8, 1, 0, 1, "R1 recovery");
    // sweep of transmit counts around a trigger (R5)
    for (int c = 0; c < 12; c++)
      apply(0, 1, 0, 0, 0, c, 6, 0, 0, 8, 1, 0, (c < 6) || (c == 0), "R5 sweep");
    wait (sb.size() == 0);
    @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule